// File: doc/BRIEF.md
# Two-Way Set-Associative Read-Only Byte Cache

This block serves byte reads from a small read-only memory through a cache that holds four 32-bit lines, arranged as two sets of two ways. A request carries an 8-bit byte address. The block checks the tags of both ways in the addressed set in the same cycle. On a hit, it returns the stored byte. On a miss, it fetches the whole 4-byte line from an external memory port in one cycle and writes it into a way. Then it repeats the lookup, which now hits, and returns the byte.

No recency history is kept. When the set has an empty way, that way is filled. When both ways are full, a free-running 8-bit LFSR picks the way to evict. Requests enter through a valid/ready channel. Responses leave through a valid/ready channel and carry the byte plus a flag telling whether the first lookup hit. Only one request is in flight at a time: `req_ready` is low while a lookup or refill is running, and also while an earlier response is still held. A response held under back-pressure keeps its data and flag unchanged until `rsp_ready` is seen. A new request may be accepted in the same cycle that the previous response is taken.

Top module: `ac2_cache`

## Requirements
- R1: After reset every way of every set is invalid, so the first access to any address misses; `req_ready` is 1 and `rsp_valid` is 0 out of reset.
- R2: Address bits [1:0] pick the byte within the line, bit [2] picks the set and bits [7:3] form the tag. A refill reads `mem_rdata` at `mem_addr` = address bits [7:2], and byte k of the line sits in `mem_rdata` bits [8k+7:8k].
- R3: A request accepted at clock edge N that hits has `rsp_valid` low during the following cycle. The response appears after edge N+1 with `rsp_hit` = 1 and the byte stored at fill time, whatever `mem_rdata` shows now.
- R4: A request accepted at edge N that misses refills a way at edge N+1. Its response appears after edge N+2 with `rsp_hit` = 0 and the freshly fetched byte.
- R5: Two lines with the same set bit but different tags are held at once, one in each way, and both then hit.
- R6: On a miss, an invalid way is used before any eviction, way 0 before way 1. A valid line in the set is not evicted while the other way is invalid.
- R7: When both ways of the set are valid, the victim way equals bit 0 of an 8-bit LFSR during the lookup cycle. The LFSR resets to 8'h01 and advances every cycle as `q <= {q[6:0], q[7]^q[5]^q[4]^q[3]}`.
- R8: While `rsp_valid` is 1 and `rsp_ready` is 0, the response and its flag stay unchanged, `req_ready` stays 0, and a request offered then is not accepted. When `rsp_ready` is 1, a new request is accepted in that same cycle.
- R9: At most one way hits for any lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A read request is offered |
| req_ready | output | 1 | The block can take a request this cycle |
| req_addr | input | 8 | Byte address of the request |
| rsp_valid | output | 1 | A response is presented |
| rsp_ready | input | 1 | The consumer takes the response this cycle |
| rsp_data | output | 8 | The addressed byte |
| rsp_hit | output | 1 | 1 if the first lookup hit, 0 if a refill was needed |
| mem_addr | output | 6 | Line address for the memory port |
| mem_rdata | input | 32 | Line read back from memory, combinational on `mem_addr` |

## Verification
Two things can fall in the same cycle: the consumer taking a held response, and the producer handing over the next request. The bench provokes this by stalling `rsp_ready` for several cycles with a competing request offered, which must be ignored. It then raises `rsp_ready` and a new request together, and judges that the request is accepted on that edge and that its lookup and response run on the normal timing. Refill and victim choice meet in the same lookup cycle. They are judged against a reference copy of the cache contents and of the specified LFSR, which predicts the hit flag and byte of every access while memory contents are changed between accesses.

// File: rtl/ac2_pkg.sv
package ac2_pkg;
  localparam int ADDR_W    = 8;
  localparam int OFF_W     = 2;
  localparam int SET_W     = 1;
  localparam int WAYS      = 2;
  localparam int RND_W     = 8;
  localparam logic [RND_W-1:0] RND_SEED = 8'h01;
  localparam logic [RND_W-1:0] RND_TAPS = 8'hB8;

  typedef logic [7:0] byte_t;
endpackage

// File: rtl/ac2_lfsr.sv
module ac2_lfsr #(
  parameter int W = 8,
  parameter logic [W-1:0] SEED = 1,
  parameter logic [W-1:0] TAPS = 'hB8,
  parameter int OUT_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] rnd
);
  logic [W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= SEED;
    else        q <= {q[W-2:0], ^(q & TAPS)};
  end

  assign rnd = q[OUT_W-1:0];
endmodule

// File: rtl/ac2_way.sv
module ac2_way #(
  parameter int SET_W  = 1,
  parameter int TAG_W  = 5,
  parameter int LINE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  set_idx,
  input  logic [TAG_W-1:0]  tag,
  input  logic              fill_en,
  input  logic [LINE_W-1:0] fill_line,
  output logic              hit,
  output logic              vld,
  output logic [LINE_W-1:0] line
);
  localparam int SETS = 1 << SET_W;

  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] data_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       valid_q <= '0;
    else if (fill_en) valid_q[set_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[set_idx]  <= tag;
      data_q[set_idx] <= fill_line;
    end
  end

  assign vld  = valid_q[set_idx];
  assign hit  = vld && (tag_q[set_idx] == tag);
  assign line = data_q[set_idx];
endmodule

// File: rtl/ac2_victim.sv
module ac2_victim #(
  parameter int WAYS  = 2,
  parameter int IDX_W = 1
) (
  input  logic [WAYS-1:0]  vld,
  input  logic [IDX_W-1:0] rnd,
  output logic [WAYS-1:0]  sel
);
  logic found;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!vld[w] && !found) begin
        sel[w] = 1'b1;
        found  = 1'b1;
      end
    end
    if (!found) sel[rnd] = 1'b1;
  end
endmodule

// File: rtl/ac2_cache.sv
module ac2_cache
  import ac2_pkg::*;
#(
  parameter int ADDR_BITS   = ADDR_W,
  parameter int OFFSET_BITS = OFF_W,
  parameter int SET_BITS    = SET_W,
  parameter int NUM_WAYS    = WAYS,
  parameter int LFSR_BITS   = RND_W,
  parameter logic [LFSR_BITS-1:0] LFSR_SEED = RND_SEED,
  parameter logic [LFSR_BITS-1:0] LFSR_TAPS = RND_TAPS
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_valid,
  output logic                              req_ready,
  input  logic [ADDR_BITS-1:0]              req_addr,
  output logic                              rsp_valid,
  input  logic                              rsp_ready,
  output logic [7:0]                        rsp_data,
  output logic                              rsp_hit,
  output logic [ADDR_BITS-OFFSET_BITS-1:0]  mem_addr,
  input  logic [(8<<OFFSET_BITS)-1:0]       mem_rdata
);
  localparam int TAG_BITS  = ADDR_BITS - OFFSET_BITS - SET_BITS;
  localparam int LINE_BITS = 8 << OFFSET_BITS;
  localparam int WAY_IDX   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1;

  logic                   busy_q, missed_q;
  logic [ADDR_BITS-1:0]   addr_q;
  logic [SET_BITS-1:0]    set_idx;
  logic [TAG_BITS-1:0]    tag;
  logic [OFFSET_BITS-1:0] off;

  logic [NUM_WAYS-1:0]  way_hit, way_vld, fill_sel;
  logic [LINE_BITS-1:0] way_line [NUM_WAYS];
  logic [LINE_BITS-1:0] hit_line;
  logic [WAY_IDX-1:0]   rnd;
  logic                 any_hit, fill_en, req_fire;
  byte_t                hit_byte;

  assign set_idx  = addr_q[OFFSET_BITS +: SET_BITS];
  assign tag      = addr_q[ADDR_BITS-1 -: TAG_BITS];
  assign off      = addr_q[OFFSET_BITS-1:0];
  assign mem_addr = addr_q[ADDR_BITS-1:OFFSET_BITS];

  assign any_hit   = |way_hit;
  assign fill_en   = busy_q && !any_hit;
  assign req_ready = !busy_q && (!rsp_valid || rsp_ready);
  assign req_fire  = req_valid && req_ready;

  ac2_lfsr #(
    .W(LFSR_BITS), .SEED(LFSR_SEED), .TAPS(LFSR_TAPS), .OUT_W(WAY_IDX)
  ) u_lfsr (
    .clk(clk), .rst_n(rst_n), .rnd(rnd)
  );

  ac2_victim #(.WAYS(NUM_WAYS), .IDX_W(WAY_IDX)) u_victim (
    .vld(way_vld), .rnd(rnd), .sel(fill_sel)
  );

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    ac2_way #(.SET_W(SET_BITS), .TAG_W(TAG_BITS), .LINE_W(LINE_BITS)) u_way (
      .clk(clk), .rst_n(rst_n),
      .set_idx(set_idx), .tag(tag),
      .fill_en(fill_en && fill_sel[w]), .fill_line(mem_rdata),
      .hit(way_hit[w]), .vld(way_vld[w]), .line(way_line[w])
    );
  end

  always_comb begin
    hit_line = '0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (way_hit[w]) hit_line = hit_line | way_line[w];
  end

  assign hit_byte = hit_line[{off, 3'b000} +: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      missed_q <= 1'b0;
      addr_q   <= '0;
    end else if (req_fire) begin
      busy_q   <= 1'b1;
      missed_q <= 1'b0;
      addr_q   <= req_addr;
    end else if (busy_q) begin
      if (any_hit) busy_q   <= 1'b0;
      else         missed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_hit   <= 1'b0;
    end else if (busy_q && any_hit) begin
      rsp_valid <= 1'b1;
      rsp_data  <= hit_byte;
      rsp_hit   <= !missed_q;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ac2_chk.sv
module ac2_chk #(
  parameter int WAYS = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [7:0]      rsp_data,
  input logic            rsp_hit,
  input logic            fill_en,
  input logic [WAYS-1:0] way_hit,
  input logic [WAYS-1:0] way_vld,
  input logic [WAYS-1:0] fill_sel
);
  // R8: a stalled response holds its contents
  a_r8_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_hit));

  // R8: no intake while a response is stalled
  a_r8_no_intake: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  // R3: the cycle after acceptance is the lookup, with no response yet
  a_r3_lookup_gap: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !rsp_valid && !req_ready);

  // R4: after a refill the repeated lookup hits
  a_r4_refill_hits: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (|way_hit) && !rsp_valid);

  // R6: an empty way is preferred over eviction
  a_r6_empty_first: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en && !(&way_vld) |-> (fill_sel & way_vld) == '0);

  // R9: hits are exclusive across ways
  a_r9_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_hit));

  // R7: exactly one way is chosen for every refill
  a_r7_one_victim: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> $countones(fill_sel) == 1);
endmodule

bind ac2_cache ac2_chk #(.WAYS(NUM_WAYS)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_data(rsp_data), .rsp_hit(rsp_hit),
  .fill_en(fill_en), .way_hit(way_hit),
  .way_vld(way_vld), .fill_sel(fill_sel)
);

// File: tb/sim_ac2_cache.sv
`timescale 1ns/1ps
module sim_ac2_cache;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [7:0]  req_addr;
  logic        rsp_valid, rsp_ready;
  logic [7:0]  rsp_data;
  logic        rsp_hit;
  logic [5:0]  mem_addr;
  logic [31:0] mem_rdata;
  logic [7:0]  cur_xor;

  int nchk = 0;
  int nbad = 0;

  always #10 clk = ~clk;

  ac2_cache u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_hit(rsp_hit),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] byte_of(input logic [7:0] a, input logic [7:0] x);
    return (a * 8'd7 + 8'd3) ^ x;
  endfunction

  // memory model: byte k of line L sits in bits [8k+7:8k] (R2)
  always_comb begin
    for (int k = 0; k < 4; k++)
      mem_rdata[k*8 +: 8] = byte_of({mem_addr, 2'(k)}, cur_xor);
  end

  // reference contents and LFSR (R7)
  logic       mval [2][2];
  logic [4:0] mtag [2][2];
  logic [7:0] mx   [2][2];
  logic [7:0] mlfsr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mlfsr <= 8'h01;
    else        mlfsr <= {mlfsr[6:0], mlfsr[7] ^ mlfsr[5] ^ mlfsr[4] ^ mlfsr[3]};
  end

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [7:0] a, input bit hold);
    int          s, hw;
    bit          eh;
    logic [4:0]  t;
    logic [7:0]  exp_d;
    @(negedge clk);
    rsp_ready = 1'b1;
    req_addr  = a;
    req_valid = 1'b1;
    #1;
    check_eq("R8 req_ready when offering", req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (hold) rsp_ready = 1'b0;
    s = a[2]; t = a[7:3]; eh = 0; hw = 0;
    for (int w = 0; w < 2; w++)
      if (mval[s][w] && mtag[s][w] == t) begin eh = 1; hw = w; end
    if (!eh) begin
      if (!mval[s][0])      hw = 0;
      else if (!mval[s][1]) hw = 1;
      else                  hw = mlfsr[0];
      mval[s][hw] = 1'b1;
      mtag[s][hw] = t;
      mx[s][hw]   = cur_xor;
    end
    exp_d = byte_of(a, mx[s][hw]);
    check_eq("R3 no response in lookup cycle", rsp_valid, 0);
    if (!eh) begin
      check_eq("R2 mem_addr during refill", mem_addr, a[7:2]);
      @(negedge clk);
      check_eq("R4 response waits for refill", rsp_valid, 0);
    end
    @(negedge clk);
    check_eq(eh ? "R3 hit response valid" : "R4 miss response valid", rsp_valid, 1);
    check_eq("R7 hit flag vs reference", rsp_hit, eh);
    check_eq("R2 byte lane data", rsp_data, exp_d);
    if (hold) begin
      req_valid = 1'b1;
      req_addr  = 8'hFC;
      repeat (3) @(negedge clk);
      check_eq("R8 held valid", rsp_valid, 1);
      check_eq("R8 held data", rsp_data, exp_d);
      check_eq("R8 held flag", rsp_hit, eh);
      check_eq("R8 no intake while held", req_ready, 0);
    end
  endtask

  task automatic t_reset();
    check_eq("R1 req_ready after reset", req_ready, 1);
    check_eq("R1 rsp_valid after reset", rsp_valid, 0);
  endtask

  task automatic t_cold_and_lanes();
    access(8'h00, 0);           // R1 cold miss
    access(8'h01, 0);           // R2 lanes on hit
    access(8'h02, 0);
    access(8'h03, 0);
  endtask

  task automatic t_stale_mem();
    cur_xor = 8'hFF;
    access(8'h02, 0);           // R3 byte from stored line
    access(8'h03, 0);
  endtask

  task automatic t_two_ways();
    access(8'h20, 0);           // R5 same set, way 1 (R6)
    access(8'h00, 0);           // R6 way 0 line survived
    access(8'h21, 0);
  endtask

  task automatic t_other_set();
    cur_xor = 8'h3C;
    access(8'h04, 0);
    access(8'h07, 0);
    access(8'h01, 0);
  endtask

  task automatic t_random_victim();
    for (int i = 0; i < 40; i++) begin
      cur_xor = 8'(i * 13);
      access({3'(((i * 5) + (i / 3)) % 4), 2'b00, 1'b0, 2'(i % 4)} , 0);  // R7
    end
  endtask

  task automatic t_backpressure();
    access(8'h09, 1);           // R8 stall with competing offer
    access(8'h0D, 0);           // R8 accept with consumption in same cycle
    access(8'h0E, 1);
    access(8'h0C, 0);
  endtask

  initial begin
    #(20 * 150000);
    nchk++;
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_addr  = 8'h00;
    rsp_ready = 1'b1;
    cur_xor   = 8'h00;
    for (int s = 0; s < 2; s++)
      for (int w = 0; w < 2; w++) begin
        mval[s][w] = 1'b0; mtag[s][w] = '0; mx[s][w] = '0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cold_and_lanes();
    t_stale_mem();
    t_two_ways();
    t_other_set();
    t_random_victim();
    t_backpressure();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule